// File: doc/BRIEF.md
# Tap-Selectable Operand Delay Line

This block is one operand lane of a pipelined multiply-accumulate datapath. A 12-bit two's-complement sample is captured into a front register on every clock. The captured sample moves into a 16-entry shift stack only on cycles where the active-low advance enable is low. When the enable is high, the stack freezes and the front register keeps tracking the input.

A registered 4-bit tap select chooses which stack entry feeds the registered operand output. This gives an adjustable alignment delay of one to sixteen stack positions. The main use is to line up operands that arrive at different times, or to hold a coefficient steady for many cycles while new data keeps arriving.

Top module: `tap_delay_lane`

## Requirements
- R1: While `rst_ni` is low, the front register, every stack entry, the tap select register and `operand_o` are cleared to zero. After reset is released, `operand_o` reads zero for every tap until new data has propagated through.
- R2: The front register loads `data_i` on every rising clock edge, whatever the level of `stk_adv_ni`. The sample that enters the stack on an advance is the `data_i` value presented one edge before that advance edge.
- R3: On a rising edge with `stk_adv_ni` low, the front register value enters stack entry 0, and every entry k moves to entry k+1. The content of the last entry is discarded.
- R4: On a rising edge with `stk_adv_ni` high, no stack entry changes. If the tap select is also held constant, `operand_o` stops changing from the second edge after the hold begins.
- R5: Tap select 0 (binary 0000) picks stack entry 0. With the enable held low, a sample on `data_i` appears on `operand_o` three edges later.
- R6: Tap select 15 (binary 1111) picks stack entry 15. With the enable held low, a sample appears on `operand_o` eighteen edges after it is presented. In general the delay is tap+3 edges.
- R7: `tap_sel_i` is registered before use. A new tap value presented at edge n selects the stack entry that drives `operand_o` at edge n+1.
- R8: Samples pass through without change as 12-bit two's complement values, with bit 11 as the sign. This includes the extremes 0x800 and 0x7FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | 12 | Signed operand sample |
| stk_adv_ni | input | 1 | Active-low stack advance enable |
| tap_sel_i | input | 4 | Stack tap select, 0 = shortest delay |
| operand_o | output | 12 | Registered selected operand |

## Verification
The bench builds the lane with its default parameters: 12-bit samples and a 16-entry stack. With these values both tap ends (0 and 15) and the full 18-edge latency are reachable within a few cycles.

Directed phases cover the following cases:
- the minimum tap and the maximum tap;
- long freezes while the input keeps changing;
- a tap that changes every cycle;
- the signed extreme values.

A long random phase then mixes enable patterns and tap values. In this phase every entry is retained, shifted and discarded many times.

// File: rtl/tap_delay_pkg.sv
package tap_delay_pkg;
  localparam int unsigned LANE_DATA_W = 12;
  localparam int unsigned LANE_DEPTH  = 16;
endpackage

// File: rtl/tap_front_reg.sv
module tap_front_reg #(
  parameter int unsigned DATA_W = tap_delay_pkg::LANE_DATA_W,
  parameter int unsigned SEL_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic [SEL_W-1:0]  tap_sel_i,
  output logic [DATA_W-1:0] front_o,
  output logic [SEL_W-1:0]  sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      front_o <= '0;
      sel_o   <= '0;
    end else begin
      front_o <= data_i;
      sel_o   <= tap_sel_i;
    end
  end

  assert_front_tracks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> front_o == $past(data_i));
  assert_sel_reg_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> sel_o == $past(tap_sel_i));
endmodule

// File: rtl/tap_shift_stack.sv
module tap_shift_stack #(
  parameter int unsigned DATA_W = tap_delay_pkg::LANE_DATA_W,
  parameter int unsigned DEPTH  = tap_delay_pkg::LANE_DEPTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_ni,
  input  logic [DATA_W-1:0] push_i,
  output logic [DATA_W-1:0] entry_o [DEPTH]
);
  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    logic [DATA_W-1:0] src;
    if (k == 0) begin : g_top
      assign src = push_i;
    end else begin : g_rest
      assign src = entry_o[k-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     entry_o[k] <= '0;
      else if (!adv_ni) entry_o[k] <= src;
    end
  end

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_ni |=> $stable(entry_o[DEPTH-1]) && $stable(entry_o[0]));
  assert_shift_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_ni |=> entry_o[DEPTH-1] == $past(entry_o[DEPTH-2]) && entry_o[0] == $past(push_i));
endmodule

// File: rtl/tap_out_mux.sv
module tap_out_mux #(
  parameter int unsigned DATA_W = tap_delay_pkg::LANE_DATA_W,
  parameter int unsigned DEPTH  = tap_delay_pkg::LANE_DEPTH,
  parameter int unsigned SEL_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] entry_i [DEPTH],
  input  logic [SEL_W-1:0]  sel_i,
  output logic [DATA_W-1:0] operand_o
);
  logic [DATA_W-1:0] pick;
  always_comb begin
    pick = '0;
    for (int k = 0; k < DEPTH; k++)
      if (sel_i == SEL_W'(k)) pick = entry_i[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) operand_o <= '0;
    else         operand_o <= pick;
  end
endmodule

// File: rtl/tap_delay_lane.sv
module tap_delay_lane #(
  parameter int unsigned DATA_W = tap_delay_pkg::LANE_DATA_W,
  parameter int unsigned DEPTH  = tap_delay_pkg::LANE_DEPTH,
  localparam int unsigned SEL_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              stk_adv_ni,
  input  logic [SEL_W-1:0]  tap_sel_i,
  output logic [DATA_W-1:0] operand_o
);
  logic [DATA_W-1:0] front_q;
  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] entry_q [DEPTH];

  tap_front_reg #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_front (
    .clk_i, .rst_ni, .data_i, .tap_sel_i, .front_o(front_q), .sel_o(sel_q)
  );

  tap_shift_stack #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_stack (
    .clk_i, .rst_ni, .adv_ni(stk_adv_ni), .push_i(front_q), .entry_o(entry_q)
  );

  tap_out_mux #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SEL_W(SEL_W)) u_mux (
    .clk_i, .rst_ni, .entry_i(entry_q), .sel_i(sel_q), .operand_o
  );

  // frozen stack and steady tap: output settles one edge later
  assert_out_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stk_adv_ni && tap_sel_i == sel_q) |=> ##1 $stable(operand_o));
  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> operand_o == '0);
endmodule

// File: tb/tap_delay_lane_bench.sv
module tap_delay_lane_bench;
  localparam int DW = 12;
  localparam int DP = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] data = '0;
  logic          adv_n = 1'b1;
  logic [3:0]    tap = '0;
  logic [DW-1:0] operand;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tap_delay_lane u_tap_delay_lane (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .stk_adv_ni(adv_n),
    .tap_sel_i(tap), .operand_o(operand)
  );

  // reference model
  logic [DW-1:0] m_stk [DP];
  logic [DW-1:0] m_front;
  logic [3:0]    m_sel;
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];
  string         phase;

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: called at negedge, models the coming posedge
  task automatic step(logic [DW-1:0] d, logic en_n, logic [3:0] s);
    data = d; adv_n = en_n; tap = s;
    exp_q.push_back(m_stk[m_sel]);
    tag_q.push_back(phase);
    if (!en_n) begin
      for (int k = DP-1; k > 0; k--) m_stk[k] = m_stk[k-1];
      m_stk[0] = m_front;
    end
    m_front = d;
    m_sel   = s;
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) check(tag_q.pop_front(), operand, exp_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < DP; k++) m_stk[k] = '0;
    m_front = '0; m_sel = '0;
    repeat (3) @(negedge clk);
    check("R1", operand, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: every tap reads zero after reset (enable frozen)
    phase = "R1";
    for (int s = 0; s < DP; s++) step(12'h5A5, 1'b1, 4'(s));

    // R5: shortest tap, 3-edge latency
    phase = "R5";
    for (int i = 0; i < 24; i++) step(12'(i * 7 + 1), 1'b0, 4'd0);

    // R6: longest tap, 18-edge latency
    phase = "R6";
    for (int i = 0; i < 40; i++) step(12'(i * 13 + 100), 1'b0, 4'd15);

    // R4/R2: freeze with moving input, then one advance
    phase = "R4";
    for (int i = 0; i < 12; i++) step(12'(i + 300), 1'b1, 4'd3);
    phase = "R2";
    step(12'h111, 1'b0, 4'd0);
    for (int i = 0; i < 4; i++) step(12'h222, 1'b1, 4'd0);

    // R3: shifting with random gaps
    phase = "R3";
    for (int i = 0; i < 60; i++) step(12'($urandom), 1'($urandom_range(0, 2) == 0), 4'($urandom));

    // R7: tap changes every cycle
    phase = "R7";
    for (int i = 0; i < 40; i++) step(12'(i * 5), 1'(i % 3 == 0), 4'(i));

    // R8: signed extremes
    phase = "R8";
    for (int i = 0; i < 30; i++) step((i % 2) ? 12'h800 : 12'h7FF, 1'b0, 4'(i % 4));

    // mixed random
    phase = "R3";
    for (int i = 0; i < 2000; i++) step(12'($urandom), 1'($urandom), 4'($urandom));

    phase = "R4";
    for (int i = 0; i < 4; i++) step('0, 1'b1, 4'd7);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule